// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit CPU bus and a cartridge's ROM and external RAM. The CPU cannot write to ROM, so any store into the lower 32 KB of the address space is taken as a command. Depending on the address, the command opens or closes the RAM, picks a ROM bank or a RAM bank, or flips the banking mode. Loads through the same bus are turned into physical addresses for a ROM of up to 128 banks of 16 KB and a RAM of up to 4 banks of 8 KB. The read data the CPU sees is steered from the right source.

The CPU sees three windows:

- 0x0000–0x3FFF is always bank 0 of the ROM.
- 0x4000–0x7FFF shows the selected ROM bank.
- 0xA000–0xBFFF shows the selected RAM bank.

A 2-bit register serves one of two purposes, chosen by the mode bit. It holds either ROM bank bits 6:5 or the RAM bank number, never both at once. In RAM-bank mode the upper ROM bits are read as zero. The fitted sizes are parameters, and bank numbers are cut down to what is fitted.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, the 5-bit low ROM bank field is 1, the 2-bit shared field is 0, the mode is 0 and external RAM is closed. A read at 0x4000 therefore gives physical ROM address 0x04000.
- R2: A write with address bits 15:13 = 000 opens external RAM when data bits 3:0 equal 0xA. Any other low nibble closes it. Data bits 7:4 play no part.
- R3: A write with address bits 15:13 = 001 loads data bits 4:0 into the low ROM bank field and leaves the shared 2-bit field as it was. When the low field is 0, it is used as 1 when forming the switchable bank.
- R4: A write with address bits 15:13 = 010 loads data bits 1:0 into the shared 2-bit field. The other data bits are ignored.
- R5: A write with address bits 15:13 = 011 sets the mode from data bit 0: 0 is ROM-upper mode and 1 is RAM-bank mode.
- R6: For addresses 0x0000–0x3FFF, rom_addr = {0, addr[13:0]}. For addresses 0x4000–0x7FFF, rom_addr = {bank, addr[13:0]}. At all times ram_addr = {ram bank, addr[12:0]}.
- R7: In mode 0 the switchable ROM bank is {shared field, low field} and the RAM bank is 0. In mode 1 the switchable ROM bank is {00, low field} and the RAM bank is the shared field.
- R8: The ROM bank is taken modulo ROM_BANKS and the RAM bank modulo RAM_BANKS. Both parameters are powers of two.
- R9: While RAM is closed, reads from 0xA000–0xBFFF return 0xFF and ram_en and ram_we stay low. While RAM is open, a selected access there raises ram_en, and ram_we follows the write strobe.
- R10: With bus_sel high, cpu_rdata is rom_rdata for addresses below 0x8000. It is ram_rdata for an open RAM window, and 0xFF everywhere else.
- R11: A write with bus_sel low or cpu_wr low, or one at 0x8000 and above, changes no bank, mode or enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus cycle addressed to the cartridge |
| cpu_wr | input | 1 | Write strobe for the current cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| rom_rdata | input | 8 | Data returned by the ROM |
| ram_rdata | input | 8 | Data returned by the external RAM |
| rom_addr | output | 14+log2(ROM_BANKS) | Physical ROM byte address |
| ram_addr | output | 13+log2(RAM_BANKS) | Physical RAM byte address |
| ram_en | output | 1 | Access strobe to the external RAM |
| ram_we | output | 1 | Write strobe to the external RAM |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The bench runs every combination of mode, shared field and low field, on the default build and on a 16-bank ROM / 2-bank RAM build. Each combination is checked against addresses computed arithmetically:

- A design that forgot the zero-to-one fix would show bank 0 in the switchable window.
- A design that kept the upper bits in RAM-bank mode would reach banks above 31 where it must not.
- A design that skipped the mask would drive address bits the smaller part does not have.

All 256 data values are written to the RAM gate. A check on the whole byte instead of the low nibble would leave the RAM wrongly open or closed. Writes with the select or the strobe low must leave the bank mapping as it was.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    // Role of the shared 2-bit field
    typedef enum logic {
        MAP_ROM_HI  = 1'b0,
        MAP_RAM_SEL = 1'b1
    } map_mode_e;

    // Command selected by address bits 14:13 of a write below 0x8000
    typedef enum logic [1:0] {
        CMD_RAM_GATE = 2'd0,
        CMD_BANK_LO  = 2'd1,
        CMD_BANK_HI  = 2'd2,
        CMD_MODE     = 2'd3
    } cmd_e;

    typedef struct packed {
        logic       ram_open;
        logic [4:0] bank_lo;
        logic [1:0] bank_hi;
        map_mode_e  mode;
    } bank_state_t;

    localparam bank_state_t BANK_STATE_RST = '{
        ram_open: 1'b0,
        bank_lo:  5'd1,
        bank_hi:  2'd0,
        mode:     MAP_ROM_HI
    };

    localparam logic [3:0] RAM_KEY     = 4'hA;
    localparam logic [7:0] OPEN_BUS    = 8'hFF;
    localparam int         ROM_WIN_AW  = 14;
    localparam int         RAM_WIN_AW  = 13;

endpackage

// File: rtl/cart_cmd_decode.sv
module cart_cmd_decode
    import cart_bank_pkg::*;
(
    input  bank_state_t cur_q,
    input  logic        wr_fire,
    input  logic [1:0]  cmd_sel,
    input  logic [7:0]  wdata,
    output bank_state_t nxt_d
);

    // Bits 7:5 carry no command content
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[7:5];

    always_comb begin
        nxt_d = cur_q;
        if (wr_fire) begin
            case (cmd_e'(cmd_sel))
                CMD_RAM_GATE: nxt_d.ram_open = (wdata[3:0] == RAM_KEY);
                CMD_BANK_LO:  nxt_d.bank_lo  = wdata[4:0];
                CMD_BANK_HI:  nxt_d.bank_hi  = wdata[1:0];
                CMD_MODE:     nxt_d.mode     = map_mode_e'(wdata[0]);
                default:      nxt_d          = cur_q;
            endcase
        end
    end

endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4,
    localparam int ROM_BW = $clog2(ROM_BANKS),
    localparam int RAM_BW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int ROM_AW = ROM_BW + ROM_WIN_AW,
    localparam int RAM_AW = RAM_BW + RAM_WIN_AW
) (
    input  bank_state_t        state_q,
    input  logic [15:0]        addr,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic               in_rom,
    output logic               in_ram
);

    localparam logic [6:0] ROM_MASK = 7'(ROM_BANKS - 1);
    localparam logic [1:0] RAM_MASK = 2'(RAM_BANKS - 1);

    logic [4:0] lo_eff;
    logic [1:0] rom_hi;
    logic [6:0] win_bank;
    logic [6:0] rom_bank_m;
    logic [1:0] ram_bank;
    logic [1:0] ram_bank_m;

    always_comb begin
        lo_eff     = (state_q.bank_lo == 5'd0) ? 5'd1 : state_q.bank_lo;
        rom_hi     = (state_q.mode == MAP_RAM_SEL) ? 2'b00 : state_q.bank_hi;
        win_bank   = addr[14] ? {rom_hi, lo_eff} : 7'd0;
        rom_bank_m = win_bank & ROM_MASK;
        ram_bank   = (state_q.mode == MAP_RAM_SEL) ? state_q.bank_hi : 2'b00;
        ram_bank_m = ram_bank & RAM_MASK;
        rom_addr   = {rom_bank_m[ROM_BW-1:0], addr[ROM_WIN_AW-1:0]};
        ram_addr   = {ram_bank_m[RAM_BW-1:0], addr[RAM_WIN_AW-1:0]};
        in_rom     = ~addr[15];
        in_ram     = (addr[15:13] == 3'b101);
    end

endmodule

// File: rtl/cart_rdata_mux.sv
module cart_rdata_mux
    import cart_bank_pkg::*;
(
    input  logic       bus_sel,
    input  logic       in_rom,
    input  logic       in_ram,
    input  logic       ram_open,
    input  logic [7:0] rom_rdata,
    input  logic [7:0] ram_rdata,
    output logic [7:0] cpu_rdata
);

    always_comb begin
        cpu_rdata = OPEN_BUS;
        if (bus_sel) begin
            if (in_rom)                   cpu_rdata = rom_rdata;
            else if (in_ram && ram_open)  cpu_rdata = ram_rdata;
        end
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4,
    localparam int ROM_BW = $clog2(ROM_BANKS),
    localparam int RAM_BW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    localparam int ROM_AW = ROM_BW + ROM_WIN_AW,
    localparam int RAM_AW = RAM_BW + RAM_WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              cpu_wr,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic [7:0]        rom_rdata,
    input  logic [7:0]        ram_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_en,
    output logic              ram_we,
    output logic [7:0]        cpu_rdata
);

    bank_state_t state_d;
    bank_state_t state_q;
    logic        wr_fire;
    logic        in_rom;
    logic        in_ram;

    // A store into the ROM half of the map is a command
    assign wr_fire = bus_sel & cpu_wr & ~cpu_addr[15];

    cart_cmd_decode u_decode (
        .cur_q   (state_q),
        .wr_fire (wr_fire),
        .cmd_sel (cpu_addr[14:13]),
        .wdata   (cpu_wdata),
        .nxt_d   (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BANK_STATE_RST;
        else        state_q <= state_d;
    end

    cart_addr_map #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS)
    ) u_map (
        .state_q  (state_q),
        .addr     (cpu_addr),
        .rom_addr (rom_addr),
        .ram_addr (ram_addr),
        .in_rom   (in_rom),
        .in_ram   (in_ram)
    );

    cart_rdata_mux u_rmux (
        .bus_sel   (bus_sel),
        .in_rom    (in_rom),
        .in_ram    (in_ram),
        .ram_open  (state_q.ram_open),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .cpu_rdata (cpu_rdata)
    );

    assign ram_en = bus_sel & in_ram & state_q.ram_open;
    assign ram_we = ram_en & cpu_wr;

endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk #(
    parameter int ROM_BANKS = 128,
    parameter int RAM_BANKS = 4,
    localparam int ROM_AW = $clog2(ROM_BANKS) + 14,
    localparam int RAM_AW = ((RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1) + 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              cpu_wr,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic [7:0]        rom_rdata,
    input logic [ROM_AW-1:0] rom_addr,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              ram_en,
    input logic              ram_we,
    input logic [7:0]        cpu_rdata
);

    p_gate_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_sel && cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA)
        |-> !ram_en);

    p_lo_zero_as_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_sel && cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata[4:0] == 5'd0)
         && cpu_addr[15:14] == 2'b01)
        |-> rom_addr[14]);

    p_fixed_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00)
        |-> (rom_addr[ROM_AW-1:14] == '0 && rom_addr[13:0] == cpu_addr[13:0]));

    p_ram_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[12:0] == cpu_addr[12:0]);

    p_closed_ram_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && cpu_addr[15:13] == 3'b101 && !ram_en) |-> cpu_rdata == 8'hFF);

    p_ram_we_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && bus_sel && cpu_addr[15:13] == 3'b101));

    p_rom_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !cpu_addr[15]) |-> cpu_rdata == rom_rdata);

    p_map_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bus_sel && cpu_wr && !cpu_addr[15]) && $stable(cpu_addr))
        |-> ($stable(rom_addr) && $stable(ram_addr)));

endmodule

bind cart_bank_ctrl cart_bank_chk #(
    .ROM_BANKS (ROM_BANKS),
    .RAM_BANKS (RAM_BANKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .rom_rdata (rom_rdata),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
);

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;

    localparam int ROM_NB_S = 16;
    localparam int RAM_NB_S = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  rom_rdata = 8'h3A;
    logic [7:0]  ram_rdata = 8'h5C;

    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_en, ram_we;
    logic [7:0]  cpu_rdata;
    logic [17:0] s_rom_addr;
    logic [13:0] s_ram_addr;
    logic        s_ram_en, s_ram_we;
    logic [7:0]  s_cpu_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the command state
    bit       m_open = 1'b0;
    bit [4:0] m_lo = 5'd1;
    bit [1:0] m_hi = 2'd0;
    bit       m_mode = 1'b0;

    always #4 clk = ~clk;

    cart_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rom_rdata(rom_rdata),
        .ram_rdata(ram_rdata), .rom_addr(rom_addr), .ram_addr(ram_addr),
        .ram_en(ram_en), .ram_we(ram_we), .cpu_rdata(cpu_rdata)
    );

    cart_bank_ctrl #(.ROM_BANKS(ROM_NB_S), .RAM_BANKS(RAM_NB_S)) u_small (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .rom_rdata(rom_rdata),
        .ram_rdata(ram_rdata), .rom_addr(s_rom_addr), .ram_addr(s_ram_addr),
        .ram_en(s_ram_en), .ram_we(s_ram_we), .cpu_rdata(s_cpu_rdata)
    );

    function automatic int exp_rom(input logic [15:0] a, input int nb);
        int lo;
        int bank;
        lo = (m_lo == 5'd0) ? 1 : int'(m_lo);
        bank = lo + (m_mode ? 0 : int'(m_hi) * 32);
        if (!a[14]) bank = 0;
        bank = bank % nb;
        return bank * 16384 + int'(a & 16'h3FFF);
    endfunction

    function automatic int exp_ram(input logic [15:0] a, input int nb);
        int rb;
        rb = m_mode ? int'(m_hi) : 0;
        rb = rb % nb;
        return rb * 8192 + int'(a & 16'h1FFF);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input bit sel, input bit we);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; bus_sel = sel; cpu_wr = we;
        @(negedge clk);
        bus_sel = 1'b0; cpu_wr = 1'b0;
        if (sel && we && !a[15]) begin
            case (a[14:13])
                2'd0: m_open = (d[3:0] == 4'hA);
                2'd1: m_lo = d[4:0];
                2'd2: m_hi = d[1:0];
                default: m_mode = d[0];
            endcase
        end
    endtask

    task automatic look(input logic [15:0] a, input bit we);
        @(negedge clk);
        cpu_addr = a; bus_sel = 1'b1; cpu_wr = we; cpu_wdata = 8'h00;
        #1;
    endtask

    task automatic chk_maps(input string req, input logic [15:0] a);
        look(a, 1'b0);
        chk(rom_addr == 21'(exp_rom(a, 128)), req, "rom_addr",
            32'(rom_addr), 32'(exp_rom(a, 128)));
        chk(s_rom_addr == 18'(exp_rom(a, ROM_NB_S)), "R8", "small rom_addr",
            32'(s_rom_addr), 32'(exp_rom(a, ROM_NB_S)));
        chk(ram_addr == 15'(exp_ram(a, 4)), req, "ram_addr",
            32'(ram_addr), 32'(exp_ram(a, 4)));
        chk(s_ram_addr == 14'(exp_ram(a, RAM_NB_S)), "R8", "small ram_addr",
            32'(s_ram_addr), 32'(exp_ram(a, RAM_NB_S)));
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state observed through the windows
        look(16'h4000, 1'b0);
        chk(rom_addr == 21'h04000, "R1", "reset bank", 32'(rom_addr), 32'h04000);
        look(16'hA010, 1'b0);
        chk(ram_addr == 15'h0010, "R1", "reset ram bank", 32'(ram_addr), 32'h0010);
        chk(ram_en == 1'b0, "R1", "reset ram closed", 32'(ram_en), 32'h0);
        chk(cpu_rdata == 8'hFF, "R1", "reset ram read", 32'(cpu_rdata), 32'hFF);

        // R10: read steering
        look(16'h0123, 1'b0);
        chk(cpu_rdata == 8'h3A, "R10", "rom read", 32'(cpu_rdata), 32'h3A);
        look(16'h7FFF, 1'b0);
        chk(cpu_rdata == 8'h3A, "R10", "rom hi read", 32'(cpu_rdata), 32'h3A);
        look(16'hC000, 1'b0);
        chk(cpu_rdata == 8'hFF, "R10", "unmapped read", 32'(cpu_rdata), 32'hFF);
        look(16'h8000, 1'b0);
        chk(cpu_rdata == 8'hFF, "R10", "unmapped read 2", 32'(cpu_rdata), 32'hFF);

        // R9: closed RAM ignores a store
        look(16'hA000, 1'b1);
        chk(ram_we == 1'b0, "R9", "closed ram_we", 32'(ram_we), 32'h0);

        // R2 / R9 / R10: every data value at the RAM gate
        for (int d = 0; d < 256; d++) begin
            bus_write((d[0] ? 16'h1FFF : 16'h0000) ^ 16'(d << 4), 8'(d), 1'b1, 1'b1);
            look(16'hA000 + 16'(d), 1'b0);
            chk(ram_en == m_open, "R2", "ram gate", 32'(ram_en), 32'(m_open));
            chk(cpu_rdata == (m_open ? 8'h5C : 8'hFF), "R9", "ram read",
                32'(cpu_rdata), m_open ? 32'h5C : 32'hFF);
        end
        bus_write(16'h0000, 8'hFA, 1'b1, 1'b1);
        look(16'hBFFF, 1'b1);
        chk(ram_we == 1'b1, "R9", "open ram_we", 32'(ram_we), 32'h1);
        chk(cpu_rdata == 8'h5C, "R10", "open ram read", 32'(cpu_rdata), 32'h5C);

        // R3 / R4 / R5 / R7 / R8: all mode, shared and low field values
        for (int md = 0; md < 2; md++) begin
            for (int hi = 0; hi < 4; hi++) begin
                for (int lo = 0; lo < 32; lo++) begin
                    bus_write(16'h6000 + 16'(lo), 8'hFE | 8'(md), 1'b1, 1'b1);
                    bus_write(16'h4000 + 16'(hi * 5), 8'hA8 | 8'(hi), 1'b1, 1'b1);
                    bus_write(16'h2000 + 16'(lo * 3), 8'hE0 | 8'(lo), 1'b1, 1'b1);
                    chk_maps(md ? "R7" : "R3", 16'h4000 + 16'((lo * 97 + hi) % 16384));
                end
            end
        end

        // R6: fixed window ignores banking in both modes
        bus_write(16'h2000, 8'h05, 1'b1, 1'b1);
        bus_write(16'h4000, 8'h03, 1'b1, 1'b1);
        bus_write(16'h6000, 8'h01, 1'b1, 1'b1);
        look(16'h3FFF, 1'b0);
        chk(rom_addr == 21'h03FFF, "R6", "fixed window mode1", 32'(rom_addr), 32'h03FFF);
        look(16'hB234, 1'b0);
        chk(ram_addr == 15'h7234, "R6", "ram window bank3", 32'(ram_addr), 32'h7234);
        bus_write(16'h6000, 8'h00, 1'b1, 1'b1);
        look(16'h0001, 1'b0);
        chk(rom_addr == 21'h00001, "R6", "fixed window mode0", 32'(rom_addr), 32'h00001);
        look(16'h4001, 1'b0);
        chk(rom_addr == 21'h194001, "R7", "bank 0x65", 32'(rom_addr), 32'h194001);

        // R11: writes that must not act
        bus_write(16'h2000, 8'h11, 1'b0, 1'b1);
        bus_write(16'h4000, 8'h00, 1'b1, 1'b0);
        bus_write(16'h6000, 8'h01, 1'b0, 1'b1);
        bus_write(16'hA000, 8'h00, 1'b1, 1'b1);
        bus_write(16'h0000, 8'h00, 1'b0, 1'b1);
        chk_maps("R11", 16'h4001);
        look(16'hA000, 1'b0);
        chk(ram_en == 1'b1, "R11", "gate kept open", 32'(ram_en), 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule